// File: doc/BRIEF.md
# Floppy Command Phase Sequencer

This block sits between the host register interface and the execution engine of a floppy disk controller core. The host writes command bytes one at a time. The first byte is an opcode, which the block decodes into a command kind and the option flags multi-track, MFM and skip-deleted. The block then collects as many further bytes as that command needs. After the last byte it starts the execution engine with a one-cycle start pulse. It waits for the engine to finish, captures the seven result bytes the engine supplies, and hands them back to the host one read at a time.

Two status outputs tell the host what to do next. `rqm` high means the block will accept a transfer, and `dio` gives the direction (0 means host to block, 1 means block to host). While the engine is busy, `rqm` is low.

The block recognises four read-class commands: read data, read deleted data, read track and read ID. An opcode that matches none of them skips execution and returns a single status byte.

The states are named as follows:
- `S_IDLE`: waiting for an opcode.
- `S_PARAM`: collecting parameter bytes.
- `S_EXEC_GO`: one cycle of start pulse.
- `S_EXEC_WAIT`: waiting for the engine.
- `S_RESULT`: returning result bytes.

The transitions are:
- IDLE→PARAM on a valid opcode write.
- IDLE→RESULT on an invalid opcode write.
- PARAM→PARAM on each non-final parameter write.
- PARAM→EXEC_GO on the final write.
- EXEC_GO→EXEC_WAIT unconditionally.
- EXEC_WAIT→RESULT on `exec_done`.
- RESULT→RESULT on each non-final read.
- RESULT→IDLE on the final read.

Top module: `fdc_cmd_sequencer`

## Requirements
- R1: After reset, `rqm`=1, `dio`=0 and `exec_start`=0, and `rd_data` is 0.
- R2: While waiting for an opcode or for parameter bytes, `rqm`=1 and `dio`=0, and each cycle with `wr_en` high consumes one byte.
- R3: An opcode whose low five bits are 00110 is read data (`cmd_code`=0), and one whose low five bits are 01100 is read deleted data (`cmd_code`=1). For both, bit 7 appears on `opt_mt`, bit 6 on `opt_mfm` and bit 5 on `opt_sk`.
- R4: Opcodes 0x02 and 0x42 are read track (`cmd_code`=2), and 0x0A and 0x4A are read ID (`cmd_code`=3). Bit 6 appears on `opt_mfm`, while `opt_mt` and `opt_sk` read 0. Every other opcode that R3 does not cover is invalid.
- R5: Read data, read deleted data and read track take nine bytes in total. In the second byte, bit 2 drives `head_sel` and bits 1:0 drive `drive_sel`; bits 7:3 are ignored. Bytes three to nine appear on `par_out` as cylinder, head, record, size, end-of-track, gap and data length, with cylinder in bits 7:0 and data length in bits 55:48.
- R6: Read ID takes two bytes in total: the opcode and the drive/head byte.
- R7: In the cycle after the edge that accepts the final command byte, `exec_start` is high for exactly one cycle. `rqm` is 0 from that cycle until the edge at which `exec_done` is seen.
- R8: The edge at which `exec_done` is seen captures `res_in`. From the next cycle, `rqm`=1 and `dio`=1, and `rd_data` presents bytes 0 to 6 of the captured value (status 0, status 1, status 2, C, H, R, N) in that order. Each `rd_en` cycle advances one byte. After the seventh read the block returns to the opcode state.
- R9: An invalid opcode gives no `exec_start` pulse. The block goes straight to the result phase and presents one byte, 0x80, and one read returns it to the opcode state.
- R10: Writes during execution or the result phase, reads outside the result phase, and `exec_done` outside execution change neither the outputs nor the byte sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Host writes `wr_data` this cycle |
| wr_data | input | 8 | Command byte from host |
| rd_en | input | 1 | Host consumes `rd_data` this cycle |
| rd_data | output | 8 | Current result byte, 0 outside the result phase |
| rqm | output | 1 | Block ready for a host transfer |
| dio | output | 1 | Transfer direction, 1 = block to host |
| exec_start | output | 1 | One-cycle start pulse to the execution engine |
| exec_done | input | 1 | Execution engine finished |
| res_in | input | 56 | Result bytes from the engine, byte 0 in bits 7:0 |
| cmd_code | output | 2 | Decoded command kind |
| opt_mt | output | 1 | Multi-track flag |
| opt_mfm | output | 1 | MFM flag |
| opt_sk | output | 1 | Skip-deleted flag |
| head_sel | output | 1 | Head from the drive/head byte |
| drive_sel | output | 2 | Drive from the drive/head byte |
| par_out | output | 56 | Collected parameter bytes, cylinder in bits 7:0 |

## Verification
Every one of the 256 opcode values is written in turn. The response tells apart the four valid command kinds, the three byte-count variants (nine, two and one byte) and the invalid path. Within the valid kinds, the opcodes that differ only in the option bits show whether each flag reaches the right output. Parameter and result bytes are derived from the opcode, so a swapped, dropped or shifted byte in either sequence appears as a wrong value. Stray writes, reads and done pulses are placed in the phases where they must be ignored.

// File: rtl/fdc_seq_pkg.sv
package fdc_seq_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_PARAM,
        S_EXEC_GO,
        S_EXEC_WAIT,
        S_RESULT
    } seq_state_t;

    typedef enum logic [1:0] {
        K_RDATA  = 2'd0,
        K_RDEL   = 2'd1,
        K_RTRACK = 2'd2,
        K_RID    = 2'd3
    } cmd_kind_t;

    typedef struct packed {
        logic      valid;
        cmd_kind_t kind;
        logic      mt;
        logic      mfm;
        logic      sk;
        logic      long_form;
    } op_info_t;

    localparam logic [7:0] ST0_BAD_OPCODE = 8'h80;

endpackage

// File: rtl/fdc_opcode_decode.sv
module fdc_opcode_decode
    import fdc_seq_pkg::*;
(
    input  logic [7:0] op,
    output op_info_t   info
);
    always_comb begin
        info = '0;
        if (op[4:0] == 5'b00110) begin
            info.valid     = 1'b1;
            info.kind      = K_RDATA;
            info.mt        = op[7];
            info.mfm       = op[6];
            info.sk        = op[5];
            info.long_form = 1'b1;
        end else if (op[4:0] == 5'b01100) begin
            info.valid     = 1'b1;
            info.kind      = K_RDEL;
            info.mt        = op[7];
            info.mfm       = op[6];
            info.sk        = op[5];
            info.long_form = 1'b1;
        end else if ({op[7], op[5:0]} == 7'b0_000010) begin
            info.valid     = 1'b1;
            info.kind      = K_RTRACK;
            info.mfm       = op[6];
            info.long_form = 1'b1;
        end else if ({op[7], op[5:0]} == 7'b0_001010) begin
            info.valid     = 1'b1;
            info.kind      = K_RID;
            info.mfm       = op[6];
            info.long_form = 1'b0;
        end
    end
endmodule

// File: rtl/fdc_param_store.sv
module fdc_param_store #(
    parameter int DW    = 8,
    parameter int PAR_N = 7,
    parameter int IDX_W = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we,
    input  logic [IDX_W-1:0]    slot,
    input  logic [DW-1:0]       din,
    output logic [DW-1:0]       drive_byte,
    output logic [PAR_N*DW-1:0] par_bus
);
    localparam int SLOTS = PAR_N + 1;

    logic [DW-1:0] mem [SLOTS];

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mem[g] <= '0;
            end else if (we && slot == IDX_W'(g)) begin
                mem[g] <= din;
            end
        end
    end

    assign drive_byte = mem[0];

    for (genvar p = 0; p < PAR_N; p++) begin : g_out
        assign par_bus[p*DW +: DW] = mem[p+1];
    end
endmodule

// File: rtl/fdc_result_bank.sv
module fdc_result_bank #(
    parameter int               DW        = 8,
    parameter int               RES_N     = 7,
    parameter int               IDX_W     = 4,
    parameter logic [DW-1:0]    INVAL_VAL = 8'h80
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic                load_inval,
    input  logic [RES_N*DW-1:0] res_in,
    input  logic [IDX_W-1:0]    idx,
    output logic [DW-1:0]       dout
);
    logic [DW-1:0] mem [RES_N];

    for (genvar g = 0; g < RES_N; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mem[g] <= '0;
            end else if (load) begin
                mem[g] <= res_in[g*DW +: DW];
            end else if (load_inval) begin
                mem[g] <= (g == 0) ? INVAL_VAL : '0;
            end
        end
    end

    always_comb begin
        dout = '0;
        for (int i = 0; i < RES_N; i++) begin
            if (idx == IDX_W'(i)) dout = mem[i];
        end
    end
endmodule

// File: rtl/fdc_cmd_sequencer.sv
module fdc_cmd_sequencer
    import fdc_seq_pkg::*;
#(
    parameter int DW    = 8,
    parameter int PAR_N = 7,
    parameter int RES_N = 7
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [DW-1:0]       wr_data,
    input  logic                rd_en,
    output logic [DW-1:0]       rd_data,
    output logic                rqm,
    output logic                dio,
    output logic                exec_start,
    input  logic                exec_done,
    input  logic [RES_N*DW-1:0] res_in,
    output logic [1:0]          cmd_code,
    output logic                opt_mt,
    output logic                opt_mfm,
    output logic                opt_sk,
    output logic                head_sel,
    output logic [1:0]          drive_sel,
    output logic [PAR_N*DW-1:0] par_out
);
    localparam int SPAN  = (PAR_N + 2 > RES_N) ? PAR_N + 2 : RES_N;
    localparam int IDX_W = $clog2(SPAN);
    localparam logic [IDX_W-1:0] LONG_LAST  = IDX_W'(PAR_N + 1);
    localparam logic [IDX_W-1:0] SHORT_LAST = IDX_W'(1);
    localparam logic [IDX_W-1:0] RES_LAST   = IDX_W'(RES_N - 1);

    seq_state_t       st_q, st_d;
    logic [IDX_W-1:0] idx_q, idx_d;
    logic [IDX_W-1:0] last_q, last_d;
    op_info_t         dec, info_q;
    logic             op_take;
    logic             param_we;
    logic             res_load;
    logic             res_inval;
    logic [DW-1:0]    drive_byte;
    logic [DW-1:0]    bank_dout;

    fdc_opcode_decode u_dec (
        .op   (wr_data[7:0]),
        .info (dec)
    );

    // Next-state and control decisions
    always_comb begin
        st_d      = st_q;
        idx_d     = idx_q;
        last_d    = last_q;
        op_take   = 1'b0;
        param_we  = 1'b0;
        res_load  = 1'b0;
        res_inval = 1'b0;
        unique case (st_q)
            S_IDLE: begin
                if (wr_en) begin
                    op_take = 1'b1;
                    if (!dec.valid) begin
                        st_d      = S_RESULT;
                        idx_d     = '0;
                        last_d    = '0;
                        res_inval = 1'b1;
                    end else begin
                        st_d   = S_PARAM;
                        idx_d  = IDX_W'(1);
                        last_d = dec.long_form ? LONG_LAST : SHORT_LAST;
                    end
                end
            end
            S_PARAM: begin
                if (wr_en) begin
                    param_we = 1'b1;
                    if (idx_q == last_q) begin
                        st_d  = S_EXEC_GO;
                        idx_d = '0;
                    end else begin
                        idx_d = idx_q + IDX_W'(1);
                    end
                end
            end
            S_EXEC_GO: begin
                st_d = S_EXEC_WAIT;
            end
            S_EXEC_WAIT: begin
                if (exec_done) begin
                    st_d     = S_RESULT;
                    res_load = 1'b1;
                    idx_d    = '0;
                    last_d   = RES_LAST;
                end
            end
            S_RESULT: begin
                if (rd_en) begin
                    if (idx_q == last_q) begin
                        st_d  = S_IDLE;
                        idx_d = '0;
                    end else begin
                        idx_d = idx_q + IDX_W'(1);
                    end
                end
            end
            default: st_d = S_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= S_IDLE;
            idx_q  <= '0;
            last_q <= '0;
        end else begin
            st_q   <= st_d;
            idx_q  <= idx_d;
            last_q <= last_d;
        end
    end

    // Decoded opcode held for the whole command
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            info_q <= '0;
        end else if (op_take && dec.valid) begin
            info_q <= dec;
        end
    end

    fdc_param_store #(
        .DW    (DW),
        .PAR_N (PAR_N),
        .IDX_W (IDX_W)
    ) u_par (
        .clk        (clk),
        .rst_n      (rst_n),
        .we         (param_we),
        .slot       (idx_q - IDX_W'(1)),
        .din        (wr_data),
        .drive_byte (drive_byte),
        .par_bus    (par_out)
    );

    fdc_result_bank #(
        .DW        (DW),
        .RES_N     (RES_N),
        .IDX_W     (IDX_W),
        .INVAL_VAL (DW'(ST0_BAD_OPCODE))
    ) u_res (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (res_load),
        .load_inval (res_inval),
        .res_in     (res_in),
        .idx        (idx_q),
        .dout       (bank_dout)
    );

    // Outputs from state
    always_comb begin
        rqm        = 1'b0;
        dio        = 1'b0;
        exec_start = 1'b0;
        rd_data    = '0;
        unique case (st_q)
            S_IDLE, S_PARAM: rqm = 1'b1;
            S_EXEC_GO:       exec_start = 1'b1;
            S_EXEC_WAIT:     rqm = 1'b0;
            S_RESULT: begin
                rqm     = 1'b1;
                dio     = 1'b1;
                rd_data = bank_dout;
            end
            default: rqm = 1'b0;
        endcase
    end

    assign cmd_code  = info_q.kind;
    assign opt_mt    = info_q.mt;
    assign opt_mfm   = info_q.mfm;
    assign opt_sk    = info_q.sk;
    assign head_sel  = drive_byte[2];
    assign drive_sel = drive_byte[1:0];
endmodule

// File: rtl/fdc_cmd_sequencer_chk.sv
module fdc_cmd_sequencer_chk (
    input logic clk,
    input logic rst_n,
    input logic wr_en,
    input logic rd_en,
    input logic rqm,
    input logic dio,
    input logic exec_start,
    input logic exec_done
);
    a_r7_start_single: assert property (@(posedge clk) disable iff (!rst_n)
        exec_start |=> !exec_start);

    a_r7_busy_on_start: assert property (@(posedge clk) disable iff (!rst_n)
        exec_start |-> !rqm);

    a_r7_start_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        exec_start |-> $past(wr_en));

    a_r7_wait_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!rqm && !exec_start && !exec_done) |=> (!rqm && !exec_start));

    a_r8_dio_needs_rqm: assert property (@(posedge clk) disable iff (!rst_n)
        dio |-> rqm);

    a_r10_read_in_cmd_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (rqm && !dio && rd_en && !wr_en) |=> (rqm && !dio));
endmodule

bind fdc_cmd_sequencer fdc_cmd_sequencer_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .rd_en      (rd_en),
    .rqm        (rqm),
    .dio        (dio),
    .exec_start (exec_start),
    .exec_done  (exec_done)
);

// File: tb/sim_fdc_cmd_sequencer.sv
module sim_fdc_cmd_sequencer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_data = '0;
    logic        rd_en = 1'b0;
    logic [7:0]  rd_data;
    logic        rqm, dio, exec_start;
    logic        exec_done = 1'b0;
    logic [55:0] res_in = '0;
    logic [1:0]  cmd_code;
    logic        opt_mt, opt_mfm, opt_sk, head_sel;
    logic [1:0]  drive_sel;
    logic [55:0] par_out;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    fdc_cmd_sequencer u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .rqm(rqm), .dio(dio),
        .exec_start(exec_start), .exec_done(exec_done), .res_in(res_in),
        .cmd_code(cmd_code), .opt_mt(opt_mt), .opt_mfm(opt_mfm),
        .opt_sk(opt_sk), .head_sel(head_sel), .drive_sel(drive_sel),
        .par_out(par_out)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic put_byte(input logic [7:0] b);
        wr_data = b;
        wr_en   = 1'b1;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic pull_byte();
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    function automatic logic [7:0] par_val(input logic [7:0] op, input int k);
        return 8'((int'(op) * 3 + k * 29 + 5) & 255);
    endfunction

    function automatic logic [7:0] res_val(input logic [7:0] op, input int k);
        return 8'((int'(op) + k * 13 + 7) & 255);
    endfunction

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 rqm", rqm, 1);
        chk("R1 dio", dio, 0);
        chk("R1 exec_start", exec_start, 0);
        chk("R1 rd_data", rd_data, 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: read while waiting for an opcode
        pull_byte();
        chk("R10 read in cmd rqm", rqm, 1);
        chk("R10 read in cmd dio", dio, 0);
        chk("R10 read in cmd rd_data", rd_data, 0);

        for (int op = 0; op < 256; op++) begin
            logic [7:0] o;
            logic       valid, long_f;
            logic [1:0] kind;
            logic       e_mt, e_sk;
            logic [7:0] dbyte;
            logic [55:0] exp_par, rbus;
            o = 8'(op);
            valid = 1'b0; long_f = 1'b0; kind = 2'd0; e_mt = 1'b0; e_sk = 1'b0;
            if (o[4:0] == 5'd6)       begin valid = 1; long_f = 1; kind = 0; e_mt = o[7]; e_sk = o[5]; end
            else if (o[4:0] == 5'd12) begin valid = 1; long_f = 1; kind = 1; e_mt = o[7]; e_sk = o[5]; end
            else if ((o & 8'hBF) == 8'h02) begin valid = 1; long_f = 1; kind = 2; end
            else if ((o & 8'hBF) == 8'h0A) begin valid = 1; long_f = 0; kind = 3; end

            chk("R2 idle rqm", rqm, 1);
            chk("R2 idle dio", dio, 0);
            put_byte(o);

            if (!valid) begin
                chk("R9 no exec_start", exec_start, 0);
                chk("R9 result rqm", rqm, 1);
                chk("R9 result dio", dio, 1);
                chk("R9 status 0x80", rd_data, 8'h80);
                exec_done = 1'b1; res_in = 56'hFFFF_FFFF_FFFF_FF;
                @(negedge clk);
                exec_done = 1'b0;
                chk("R10 stray done ignored", rd_data, 8'h80);
                pull_byte();
                chk("R9 back to cmd rqm", rqm, 1);
                chk("R9 back to cmd dio", dio, 0);
            end else begin
                chk("R4/R3 cmd_code", cmd_code, kind);
                chk("R3 opt_mt", opt_mt, e_mt);
                chk("R3 opt_mfm", opt_mfm, o[6]);
                chk("R4 opt_sk", opt_sk, e_sk);
                chk("R2 param rqm", rqm, 1);
                chk("R2 param dio", dio, 0);
                dbyte = o ^ 8'hA5;
                if (long_f) begin
                    put_byte(dbyte);
                    for (int k = 0; k < 7; k++) begin
                        chk("R5 no early start", exec_start, 0);
                        put_byte(par_val(o, k));
                    end
                end else begin
                    put_byte(dbyte);
                end
                chk(long_f ? "R5 exec_start" : "R6 exec_start", exec_start, 1);
                chk("R7 rqm low at start", rqm, 0);
                // stray write during execution
                put_byte(8'h06);
                chk("R7 single pulse", exec_start, 0);
                chk("R7 busy rqm", rqm, 0);
                chk("R5 head_sel", head_sel, dbyte[2]);
                chk("R5 drive_sel", drive_sel, dbyte[1:0]);
                if (long_f) begin
                    exp_par = '0;
                    for (int k = 0; k < 7; k++) exp_par[k*8 +: 8] = par_val(o, k);
                    chk("R5 par_out", par_out, exp_par);
                end
                pull_byte();
                chk("R10 read in exec rqm", rqm, 0);
                chk("R10 stray write cmd_code", cmd_code, kind);
                rbus = '0;
                for (int k = 0; k < 7; k++) rbus[k*8 +: 8] = res_val(o, k);
                res_in = rbus;
                exec_done = 1'b1;
                @(negedge clk);
                exec_done = 1'b0;
                res_in = '0;
                chk("R8 result rqm", rqm, 1);
                chk("R8 result dio", dio, 1);
                for (int k = 0; k < 7; k++) begin
                    chk("R8 result byte", rd_data, res_val(o, k));
                    if (k == 3) begin
                        put_byte(8'h4A);
                        chk("R10 write in result", rd_data, res_val(o, k));
                    end
                    pull_byte();
                end
                chk("R8 back to cmd rqm", rqm, 1);
                chk("R8 back to cmd dio", dio, 0);
                chk("R8 rd_data idle", rd_data, 0);
            end
        end
        finish_run();
    end
endmodule